// File: doc/BRIEF.md
# Word-Serial Timestamp Record Queue

This block keeps event timestamp records for one port direction of a precision time protocol port. A capture strobe loads one record, made of a 3-bit event tag, a 48-bit seconds count, a 32-bit nanoseconds count, a 64-bit clock identity, a 16-bit source port number and a 16-bit sequence number. Records wait in a first-in first-out store of parameterised depth, 90 by default.

A host drains the store through one 16-bit read-data port. Each read returns one word of the record at the head and moves a word cursor forward. The cursor, an enable bit and a saturating count of dropped records all appear in one status word. A not-empty flag lets the host poll before it starts a record. Because the store pops only after the last word, a host that loses its place can see this from a non-zero cursor.

Top module: `tsrec_fifo`

## Requirements
- R1: A synchronous active-high reset empties the store and clears the cursor, the drop count and the enable bit, so the status word reads 0x0000 and the not-empty flag is low.
- R2: A record is read as twelve 16-bit words. The first word is the tag word. Next come the seconds (3 words), the nanoseconds (2 words) and the clock identity (4 words), each with its most significant word first. The port number and then the sequence number close the record.
- R3: The tag word carries the 3-bit event tag in bits 2:0, and its bits 15:3 read zero. The tag codes are 1 Sync, 2 Pdelay_Req, 3 Pdelay_Resp and 4 Delay_Req. The store keeps any 3-bit value as given.
- R4: The status word shows the word cursor in bits 12:8. The cursor reads 0 when the next data read returns a record's first word. Each data read of a stored record adds one to it. The read of word 11 returns it to 0 and pops the record.
- R5: Status bit 15 is the capture enable. A status write loads it from write-data bit 15. While it is 0, capture strobes change nothing.
- R6: The store holds DEPTH records, 90 by default. An enabled capture while the store is full, with no pop in the same cycle, is dropped and adds one to the drop count in status bits 7:4.
- R7: The drop count stops at 15. Any status write clears it, and a clear takes priority over a drop in the same cycle.
- R8: A data read while the store is empty returns 0x0000 and leaves the cursor unchanged.
- R9: A capture and a pop in the same cycle both take effect. A full store therefore accepts the new record without a drop, and the new record comes out after all the older ones.
- R10: The not-empty flag is high while at least one record is held, and this counts a record that is partly read. The flag falls with the pop of the last record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_stb | input | 1 | Capture strobe, one record per cycle |
| cap_tag | input | 3 | Event tag of the captured record |
| cap_sec | input | 48 | Seconds field |
| cap_nsec | input | 32 | Nanoseconds field |
| cap_clkid | input | 64 | Source clock identity |
| cap_portnum | input | 16 | Source port number |
| cap_seqid | input | 16 | Sequence number |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 16 | Status write data, bit 15 is the enable |
| stat_rdata | output | 16 | Status word: enable, cursor, drop count |
| data_rd | input | 1 | Data read strobe, advances the cursor |
| data_rdata | output | 16 | Word at the cursor of the head record |
| not_empty | output | 1 | At least one record held |
| drop_count | output | 4 | Saturating count of dropped records |

## Verification
The hardest case to reach is a capture arriving on the same edge as the pop of the head record while the store is full. It needs 90 records already held, a head record read up to its last word, and a capture strobe timed to the twelfth read. The stimulus fills the store, first saturates the drop count and clears it, then reads the head record up to word 11. It raises the capture strobe and the last read together, then checks that the drop count does not change. Finally it drains all records to confirm that the new record comes out last.

// File: rtl/tsrec_pkg.sv
`timescale 1ns/1ps
package tsrec_pkg;
   localparam int WORD_W    = 16;
   localparam int TAG_W     = 3;
   localparam int SEC_W     = 48;
   localparam int NSEC_W    = 32;
   localparam int CLKID_W   = 64;
   localparam int PORTNUM_W = 16;
   localparam int SEQID_W   = 16;

   // layout of the 16-bit status word
   localparam int EN_BIT    = 15;
   localparam int POS_LSB   = 8;
   localparam int POS_W     = 5;
   localparam int DROP_LSB  = 4;
   localparam int DROP_W    = 4;

   typedef struct packed {
      logic [TAG_W-1:0]     tag;
      logic [SEC_W-1:0]     sec;
      logic [NSEC_W-1:0]    nsec;
      logic [CLKID_W-1:0]   clkid;
      logic [PORTNUM_W-1:0] portnum;
      logic [SEQID_W-1:0]   seqid;
   } tsrec_t;

   localparam int REC_BITS      = $bits(tsrec_t);
   localparam int TAG_PAD       = WORD_W - TAG_W;
   localparam int FLAT_W        = WORD_W + SEC_W + NSEC_W + CLKID_W + PORTNUM_W + SEQID_W;
   localparam int WORDS_PER_REC = FLAT_W / WORD_W;

   // widen the tag to a full word so every field is word aligned
   function automatic logic [FLAT_W-1:0] flatten(input tsrec_t r);
      return {{TAG_PAD{1'b0}}, r.tag, r.sec, r.nsec, r.clkid, r.portnum, r.seqid};
   endfunction
endpackage

// File: rtl/tsrec_store.sv
`timescale 1ns/1ps
module tsrec_store
   import tsrec_pkg::*;
#(
   parameter int DEPTH = 90
) (
   input  logic   clk,
   input  logic   rst,
   input  logic   push,
   input  logic   pop,
   input  tsrec_t wr_rec,
   output tsrec_t rd_rec,
   output logic   empty,
   output logic   dropped
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_depth_chk
      $error("tsrec_store: DEPTH must be at least 2");
   end

   tsrec_t           mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] count;
   logic             full, do_pop, do_push;

   assign empty   = (count == '0);
   assign full    = (count == CNT_W'(DEPTH));
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);
   assign dropped = push && full && !do_pop;

   // the pointer wrap is free for power-of-two depths, a compare otherwise
   if ((1 << PTR_W) == DEPTH) begin : g_wrap_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         if (do_push && !do_pop)      count <= count + 1'b1;
         else if (do_pop && !do_push) count <= count - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wr_rec;
   end

   assign rd_rec = mem[rd_ptr];
endmodule

// File: rtl/tsrec_serializer.sv
`timescale 1ns/1ps
module tsrec_serializer
   import tsrec_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_req,
   input  logic              have_rec,
   input  tsrec_t            rec,
   output logic [WORD_W-1:0] word,
   output logic [POS_W-1:0]  pos,
   output logic              pop
);
   localparam logic [POS_W-1:0] LAST_POS = POS_W'(WORDS_PER_REC - 1);

   if (WORDS_PER_REC > (1 << POS_W)) begin : g_pos_chk
      $error("tsrec_serializer: cursor field too narrow for the record");
   end

   logic [FLAT_W-1:0] flat;
   logic [WORD_W-1:0] words [WORDS_PER_REC];
   logic              advance;

   assign flat = flatten(rec);

   // word 0 is the most significant slice of the flattened record
   for (genvar g = 0; g < WORDS_PER_REC; g++) begin : g_slice
      assign words[g] = flat[FLAT_W-1-g*WORD_W -: WORD_W];
   end

   always_comb begin
      word = '0;
      if (have_rec) begin
         for (int k = 0; k < WORDS_PER_REC; k++) begin
            if (pos == POS_W'(k)) word = words[k];
         end
      end
   end

   assign advance = rd_req && have_rec;
   assign pop     = advance && (pos == LAST_POS);

   always_ff @(posedge clk) begin
      if (rst)          pos <= '0;
      else if (pop)     pos <= '0;
      else if (advance) pos <= pos + 1'b1;
   end
endmodule

// File: rtl/tsrec_drop_ctr.sv
`timescale 1ns/1ps
module tsrec_drop_ctr #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   if (W < 1) begin : g_w_chk
      $error("tsrec_drop_ctr: W must be positive");
   end

   always_ff @(posedge clk) begin
      if (rst || clr)         cnt <= '0;
      else if (inc && !(&cnt)) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/tsrec_fifo.sv
`timescale 1ns/1ps
module tsrec_fifo
   import tsrec_pkg::*;
#(
   parameter int DEPTH = 90
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 cap_stb,
   input  logic [TAG_W-1:0]     cap_tag,
   input  logic [SEC_W-1:0]     cap_sec,
   input  logic [NSEC_W-1:0]    cap_nsec,
   input  logic [CLKID_W-1:0]   cap_clkid,
   input  logic [PORTNUM_W-1:0] cap_portnum,
   input  logic [SEQID_W-1:0]   cap_seqid,
   input  logic                 stat_wr,
   input  logic [WORD_W-1:0]    stat_wdata,
   output logic [WORD_W-1:0]    stat_rdata,
   input  logic                 data_rd,
   output logic [WORD_W-1:0]    data_rdata,
   output logic                 not_empty,
   output logic [DROP_W-1:0]    drop_count
);
   if (EN_BIT >= WORD_W || POS_LSB + POS_W > EN_BIT || DROP_LSB + DROP_W > POS_LSB) begin : g_stat_chk
      $error("tsrec_fifo: status fields overlap");
   end

   logic            en;
   logic            empty, dropped, pop;
   logic            push;
   logic [POS_W-1:0] pos;
   tsrec_t          wr_rec, rd_rec;
   logic [WORD_W-2:0] unused_wdata;

   assign unused_wdata = stat_wdata[WORD_W-2:0];

   always_ff @(posedge clk) begin
      if (rst)          en <= 1'b0;
      else if (stat_wr) en <= stat_wdata[EN_BIT];
   end

   assign push   = cap_stb && en;
   assign wr_rec = '{tag: cap_tag, sec: cap_sec, nsec: cap_nsec, clkid: cap_clkid,
                     portnum: cap_portnum, seqid: cap_seqid};

   tsrec_store #(.DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .rst     (rst),
      .push    (push),
      .pop     (pop),
      .wr_rec  (wr_rec),
      .rd_rec  (rd_rec),
      .empty   (empty),
      .dropped (dropped)
   );

   tsrec_serializer u_ser (
      .clk      (clk),
      .rst      (rst),
      .rd_req   (data_rd),
      .have_rec (!empty),
      .rec      (rd_rec),
      .word     (data_rdata),
      .pos      (pos),
      .pop      (pop)
   );

   tsrec_drop_ctr #(.W(DROP_W)) u_drop (
      .clk (clk),
      .rst (rst),
      .clr (stat_wr),
      .inc (dropped),
      .cnt (drop_count)
   );

   assign not_empty = !empty;

   always_comb begin
      stat_rdata = '0;
      stat_rdata[EN_BIT] = en;
      stat_rdata[POS_LSB +: POS_W] = pos;
      stat_rdata[DROP_LSB +: DROP_W] = drop_count;
   end
endmodule

// File: rtl/tsrec_fifo_chk.sv
`timescale 1ns/1ps
module tsrec_fifo_chk
   import tsrec_pkg::*;
(
   input logic                 clk,
   input logic                 rst,
   input logic                 cap_stb,
   input logic                 stat_wr,
   input logic [WORD_W-1:0]    stat_rdata,
   input logic                 data_rd,
   input logic [WORD_W-1:0]    data_rdata,
   input logic                 not_empty,
   input logic [DROP_W-1:0]    drop_count
);
   logic [POS_W-1:0] pos;
   logic             en;
   assign pos = stat_rdata[POS_LSB +: POS_W];
   assign en  = stat_rdata[EN_BIT];

   // R1
   reset_clears_chk: assert property (@(posedge clk)
      rst |=> (stat_rdata == '0 && !not_empty));

   // R4
   cursor_step_chk: assert property (@(posedge clk) disable iff (rst)
      (data_rd && not_empty && pos < POS_W'(WORDS_PER_REC - 1)) |=> pos == $past(pos) + 1'b1);

   // R4
   cursor_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (data_rd && not_empty && pos == POS_W'(WORDS_PER_REC - 1)) |=> pos == '0);

   // R4
   cursor_range_chk: assert property (@(posedge clk) disable iff (rst)
      pos < POS_W'(WORDS_PER_REC));

   // R5
   disabled_capture_chk: assert property (@(posedge clk) disable iff (rst)
      (!en && !stat_wr && !not_empty) |=> !not_empty);

   // R6
   drop_step_chk: assert property (@(posedge clk) disable iff (rst)
      !stat_wr |=> (drop_count == $past(drop_count) || drop_count == $past(drop_count) + 1'b1));

   // R7
   drop_sat_chk: assert property (@(posedge clk) disable iff (rst)
      (&drop_count && !stat_wr) |=> &drop_count);

   // R7
   drop_clear_chk: assert property (@(posedge clk) disable iff (rst)
      stat_wr |=> drop_count == '0);

   // R8
   empty_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
      !not_empty |-> data_rdata == '0);

   // R8
   empty_read_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (data_rd && !not_empty) |=> $stable(pos));

   // R9
   same_cycle_no_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (cap_stb && en && data_rd && not_empty && pos == POS_W'(WORDS_PER_REC - 1) && !stat_wr)
      |=> $stable(drop_count));
endmodule

bind tsrec_fifo tsrec_fifo_chk u_tsrec_fifo_chk (
   .clk        (clk),
   .rst        (rst),
   .cap_stb    (cap_stb),
   .stat_wr    (stat_wr),
   .stat_rdata (stat_rdata),
   .data_rd    (data_rd),
   .data_rdata (data_rdata),
   .not_empty  (not_empty),
   .drop_count (drop_count)
);

// File: tb/test_tsrec_fifo.sv
`timescale 1ns/1ps
module test_tsrec_fifo;
   logic        clk = 1'b0;
   logic        rst;
   logic        cap_stb;
   logic [2:0]  cap_tag;
   logic [47:0] cap_sec;
   logic [31:0] cap_nsec;
   logic [63:0] cap_clkid;
   logic [15:0] cap_portnum, cap_seqid;
   logic        stat_wr;
   logic [15:0] stat_wdata, stat_rdata;
   logic        data_rd;
   logic [15:0] data_rdata;
   logic        not_empty;
   logic [3:0]  drop_count;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   tsrec_fifo i_tsrec_fifo (
      .clk, .rst, .cap_stb, .cap_tag, .cap_sec, .cap_nsec, .cap_clkid,
      .cap_portnum, .cap_seqid, .stat_wr, .stat_wdata, .stat_rdata,
      .data_rd, .data_rdata, .not_empty, .drop_count
   );

   // stimulus table: tag, seconds, nanoseconds, clock identity, port, sequence
   localparam int NVEC = 5;
   localparam logic [178:0] VEC [NVEC] = '{
      {3'd1, 48'h0000_1234_5678, 32'h0ABC_DEF0, 64'h0011_2233_4455_6677, 16'h0001, 16'h00A0},
      {3'd2, 48'hFFFF_0000_FFFF, 32'h3B9A_C9FF, 64'hDEAD_BEEF_CAFE_F00D, 16'h0002, 16'hFFFF},
      {3'd3, 48'h8000_0000_0001, 32'h0000_0001, 64'h8000_0000_0000_0001, 16'h8000, 16'h0000},
      {3'd4, 48'h0000_0000_0000, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 16'hFFFF, 16'h1234},
      {3'd7, 48'hA5A5_5A5A_A5A5, 32'h5A5A_A5A5, 64'h0123_4567_89AB_CDEF, 16'h7E7E, 16'h4321}
   };

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic capture(input logic [178:0] r);
      {cap_tag, cap_sec, cap_nsec, cap_clkid, cap_portnum, cap_seqid} = r;
      cap_stb = 1'b1;
      tick();
      cap_stb = 1'b0;
   endtask

   task automatic stat_write(input logic [15:0] v);
      stat_wdata = v;
      stat_wr = 1'b1;
      tick();
      stat_wr = 1'b0;
   endtask

   task automatic read_word(input logic [15:0] exp, input int exp_pos, input string req);
      check(data_rdata == exp, req, data_rdata, exp);
      check(stat_rdata[12:8] == 5'(exp_pos), "R4 cursor", stat_rdata[12:8], exp_pos);
      data_rd = 1'b1;
      tick();
      data_rd = 1'b0;
   endtask

   function automatic logic [15:0] word_of(input logic [178:0] r, input int k);
      logic [191:0] flat;
      flat = {13'b0, r};
      return flat[191-16*k -: 16];
   endfunction

   function automatic logic [178:0] seq_rec(input logic [15:0] s);
      return {3'd1, 48'(s), 32'h100, 64'h55, 16'h3, s};
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000 && !done) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         finish_run();
      end
   end

   initial begin
      rst = 1'b1; cap_stb = 0; cap_tag = 0; cap_sec = 0; cap_nsec = 0; cap_clkid = 0;
      cap_portnum = 0; cap_seqid = 0; stat_wr = 0; stat_wdata = 0; data_rd = 0;
      repeat (3) tick();
      rst = 1'b0;

      // R1 reset state
      check(stat_rdata == 16'h0000, "R1 status", stat_rdata, 0);
      check(!not_empty, "R1 not_empty", not_empty, 0);

      // R8 empty read
      read_word(16'h0000, 0, "R8 empty read data");
      check(stat_rdata[12:8] == 0, "R8 cursor held", stat_rdata[12:8], 0);

      // R5 capture ignored while disabled
      capture(VEC[0]);
      check(!not_empty, "R5 disabled capture", not_empty, 0);
      stat_write(16'h8000);
      check(stat_rdata[15], "R5 enable bit", stat_rdata[15], 1);

      // table loop: R2 order, R3 tag word, R4 cursor, R10 flag
      for (int v = 0; v < NVEC; v++) begin
         capture(VEC[v]);
         check(not_empty, "R10 flag after capture", not_empty, 1);
         for (int k = 0; k < 12; k++) begin
            read_word(word_of(VEC[v], k), k, (k == 0) ? "R3 tag word" : "R2 word order");
            if (k < 11) check(not_empty, "R10 flag during record", not_empty, 1);
         end
         check(!not_empty, "R10 flag after pop", not_empty, 0);
         check(stat_rdata[12:8] == 0, "R4 cursor wrapped", stat_rdata[12:8], 0);
      end

      // R6 fill to capacity then overflow
      for (int i = 0; i < 90; i++) capture(seq_rec(16'(i)));
      check(drop_count == 0, "R6 no drop at capacity", drop_count, 0);
      capture(seq_rec(16'hAAAA));
      check(drop_count == 1, "R6 first drop", drop_count, 1);
      check(stat_rdata[7:4] == 1, "R6 status drop field", stat_rdata[7:4], 1);
      for (int i = 0; i < 15; i++) capture(seq_rec(16'hAAAA));
      check(drop_count == 15, "R7 saturate", drop_count, 15);
      stat_write(16'h8000);
      check(drop_count == 0, "R7 clear on write", drop_count, 0);
      check(stat_rdata[15], "R5 enable kept", stat_rdata[15], 1);

      // R9 capture and pop in the same cycle while full
      for (int k = 0; k < 11; k++) read_word(word_of(seq_rec(16'h0), k), k, "R2 head record");
      check(data_rdata == 16'h0000, "R2 head seq word", data_rdata, 0);
      {cap_tag, cap_sec, cap_nsec, cap_clkid, cap_portnum, cap_seqid} = seq_rec(16'h0F0F);
      cap_stb = 1'b1;
      data_rd = 1'b1;
      tick();
      cap_stb = 1'b0;
      data_rd = 1'b0;
      check(drop_count == 0, "R9 no drop on same-cycle pop", drop_count, 0);
      for (int i = 1; i <= 90; i++) begin
         logic [15:0] es;
         es = (i == 90) ? 16'h0F0F : 16'(i);
         for (int k = 0; k < 11; k++) begin
            data_rd = 1'b1;
            tick();
         end
         data_rd = 1'b0;
         check(data_rdata == es, "R9 drain order", data_rdata, es);
         data_rd = 1'b1;
         tick();
         data_rd = 1'b0;
      end
      check(!not_empty, "R10 empty after drain", not_empty, 0);
      read_word(16'h0000, 0, "R8 empty read after drain");

      // R1 reset in the middle of a record
      capture(VEC[1]);
      for (int k = 0; k < 3; k++) read_word(word_of(VEC[1], k), k, "R2 partial");
      rst = 1'b1;
      tick();
      rst = 1'b0;
      check(stat_rdata == 16'h0000, "R1 status after mid reset", stat_rdata, 0);
      check(!not_empty, "R1 empty after mid reset", not_empty, 0);
      capture(VEC[2]);
      check(!not_empty, "R5 disabled after reset", not_empty, 0);

      finish_run();
   end
endmodule